// File: doc/BRIEF.md
# Digital Mixing Phase Detector with Numerically Controlled Local Sine

This block measures the phase relation between a sampled external reference tone and a locally synthesised sine of the same nominal frequency. Each accepted 16-bit signed reference sample is multiplied by a 16-bit sine value. That sine value is read from a quarter-wave table that is addressed by a 32-bit phase accumulator. The accumulator advances by a programmable tuning word for every accepted sample, so the local tone runs at tuning_word / 2^32 of the sample rate.

The 32-bit product keeps its full width through a third-order cascaded integrator-comb decimator. The decimator ratio is a power of two chosen by a small selector, and it produces one signed 24-bit phase-error word per block. When the reference and the local sine are in quadrature, the error word averages to zero. A loop controller that drives a tuning DAC therefore steers toward that point. The sample arithmetic has no analog stage, so the detector gain and offset cannot drift.

Top module: `dmix_phase_det`

## Requirements
- R1: After a synchronous reset, err_valid is 0 and err_word is 0 until the first complete block has been accepted.
- R2: The phase accumulator starts at 0 after reset. The first accepted sample uses phase 0, and each accepted sample then adds tune_word modulo 2^32. A step of 0xF0000000 therefore behaves exactly as a step of minus 0x10000000.
- R3: With any sample value, including a constant -32768, no stage overflows. Every error word equals the exact floor-scaled result given in R6.
- R4: The local sine for phase p is round(32767 * sin(2*pi*(i + 0.5)/1024)), where i = p[31:22]. It is built from 256 quarter-wave entries, and the upper two bits of i select mirror and sign.
- R5: Each accepted sample is multiplied as a signed value by its local sine value. The full signed 32-bit product x[n] reaches the filter.
- R6: dec_sel gives L, where a value of 0 is treated as 1 and a value above 6 is treated as 6, and the block ratio is R = 2^L. Let y[n] be x[n] passed three times through a length-R running sum with zero history. Output word j is then floor(y[jR+R-1] / 2^(3L+8)), delivered as 24-bit two's complement.
- R7: err_valid is a single-cycle pulse, given exactly once per R accepted samples.
- R8: Cycles with ref_valid low change neither the phase nor the filter, whatever ref_sample holds.
- R9: A reference in phase with the local sine gives a large positive steady error word. A reference in quadrature gives a steady word near zero.
- R10: A synchronous reset during a stream clears the accumulator, the integrators, the comb delays and the block counter. The next stream then behaves as it would from power-up.
- R11: err_valid rises five clock edges after the sample that completes a block is accepted, counting the accepting edge as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | Qualifies ref_sample in this cycle |
| ref_sample | input | 16 | Signed reference sample |
| tune_word | input | 32 | Phase step per accepted sample |
| dec_sel | input | 3 | Decimation exponent L (ratio 2^L) |
| err_valid | output | 1 | One-cycle pulse per decimated word |
| err_word | output | 24 | Signed filtered phase-error word |

## Verification
The bench builds the block with its default widths: 16-bit samples, a 32-bit phase, a maximum ratio exponent of 6 and a 24-bit error word. With these widths every ratio from 2 to 64 can be selected, and so can the out-of-range selector codes 0 and 7. The largest ratio together with a constant -32768 input drives the full 50-bit growth of the integrators. A step with the top bit set exercises the accumulator wrap. Idle cycles inserted between samples, and resets applied in the middle of a block, show that the filter history depends only on accepted samples since reset.

// File: rtl/dmix_pkg.sv
package dmix_pkg;

    localparam int SAMP_W    = 16;
    localparam int PHASE_W   = 32;
    localparam int IDX_W     = 10;
    localparam int QADDR_W   = IDX_W - 2;
    localparam int QDEPTH    = 1 << QADDR_W;
    localparam int PROD_W    = 2 * SAMP_W;
    localparam int CIC_ORDER = 3;
    localparam int LOG2_RMAX = 6;
    localparam int ACC_W     = PROD_W + CIC_ORDER * LOG2_RMAX;
    localparam int OUT_W     = 24;
    localparam int SEL_W     = 3;
    localparam int SINE_PEAK = (1 << (SAMP_W - 1)) - 1;
    localparam real TWO_PI   = 6.283185307179586;

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    // request toward the sine table: quadrant, quarter address, sample
    typedef struct packed {
        logic               vld;
        logic [1:0]         quad;
        logic [QADDR_W-1:0] addr;
        samp_t              smp;
    } lookup_req_t;

    // sample aligned with its local sine value
    typedef struct packed {
        logic  vld;
        samp_t smp;
        samp_t sine;
    } mix_pair_t;

    // registered mixer product
    typedef struct packed {
        logic  vld;
        prod_t prod;
    } mix_prod_t;

    // quarter-wave entry a, sampled half a step into its bin
    function automatic samp_t quarter_val(input int a);
        real ang;
        real v;
        int  r;
        ang = TWO_PI * (real'(a) + 0.5) / real'(1 << IDX_W);
        v   = real'(SINE_PEAK) * $sin(ang);
        r   = $rtoi(v + 0.5);
        return r[SAMP_W-1:0];
    endfunction

endpackage

// File: rtl/dmix_nco.sv
module dmix_nco
    import dmix_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_vld,
    input  samp_t              in_smp,
    input  logic [PHASE_W-1:0] step,
    output mix_pair_t          pair_o
);

    logic [PHASE_W-1:0] phase_q;
    lookup_req_t        req_q;
    mix_pair_t          pair_q;
    samp_t              qrom [QDEPTH];
    logic [QADDR_W-1:0] rd_addr;
    samp_t              mag;

    // quarter-wave table, computed at elaboration
    generate
        for (genvar g = 0; g < QDEPTH; g++) begin : g_qrom
            assign qrom[g] = quarter_val(g);
        end
    endgenerate

    // accumulator and table request
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            req_q   <= '0;
        end else begin
            req_q.vld <= in_vld;
            if (in_vld) begin
                phase_q    <= phase_q + step;
                req_q.quad <= phase_q[PHASE_W-1 -: 2];
                req_q.addr <= phase_q[PHASE_W-3 -: QADDR_W];
                req_q.smp  <= in_smp;
            end
        end
    end

    // odd quadrants read the table backwards, upper half negates
    always_comb begin
        rd_addr = req_q.quad[0] ? ~req_q.addr : req_q.addr;
        mag     = qrom[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
        end else begin
            pair_q.vld  <= req_q.vld;
            pair_q.smp  <= req_q.smp;
            pair_q.sine <= req_q.quad[1] ? -mag : mag;
        end
    end

    assign pair_o = pair_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(phase_q))
        else $error("phase moved without a sample"); // R8

    AST_SINE_RANGE: assert property (@(posedge clk) disable iff (rst)
        pair_q.vld |-> (pair_q.sine != {1'b1, {(SAMP_W-1){1'b0}}}))
        else $error("sine reached negative full scale"); // R4

    AST_SINE_SIGN: assert property (@(posedge clk) disable iff (rst)
        (pair_q.vld && pair_q.sine != '0) |-> (pair_q.sine[SAMP_W-1] == $past(req_q.quad[1])))
        else $error("sine sign disagrees with quadrant"); // R4

endmodule

// File: rtl/dmix_mixer.sv
module dmix_mixer
    import dmix_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  mix_pair_t pair_i,
    output mix_prod_t prod_o
);

    mix_prod_t prod_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
        end else begin
            prod_q.vld  <= pair_i.vld;
            prod_q.prod <= prod_t'($signed(pair_i.smp)) * prod_t'($signed(pair_i.sine));
        end
    end

    assign prod_o = prod_q;

    AST_PROD_SIGN: assert property (@(posedge clk) disable iff (rst)
        (pair_i.vld && pair_i.smp != '0 && pair_i.sine != '0)
        |=> (prod_q.prod[PROD_W-1] == ($past(pair_i.smp[SAMP_W-1]) ^ $past(pair_i.sine[SAMP_W-1]))))
        else $error("product sign wrong"); // R5

endmodule

// File: rtl/dmix_cic.sv
module dmix_cic
    import dmix_pkg::*;
#(
    parameter int ORDER  = CIC_ORDER,
    parameter int IN_W   = PROD_W,
    parameter int LG_MAX = LOG2_RMAX,
    parameter int A_W    = IN_W + ORDER * LG_MAX,
    parameter int O_W    = OUT_W,
    parameter int S_W    = SEL_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_vld,
    input  logic signed [IN_W-1:0] in_data,
    input  logic [S_W-1:0]        sel,
    output logic                  out_vld,
    output logic [O_W-1:0]        out_data
);

    localparam int CNT_W = LG_MAX;
    localparam int TRIM  = IN_W - O_W;

    logic [S_W-1:0]         sel_c;
    logic [CNT_W-1:0]       cnt_q;
    logic [CNT_W-1:0]       cnt_last;
    logic signed [A_W-1:0]  x_ext;
    logic signed [A_W-1:0]  integ_q [ORDER];
    logic signed [A_W-1:0]  integ_d [ORDER];
    logic signed [A_W-1:0]  comb_z  [ORDER];
    logic signed [A_W-1:0]  comb_d  [ORDER];
    logic signed [A_W-1:0]  dec_q;
    logic signed [A_W-1:0]  scaled;
    logic                   dec_vld;
    logic                   out_vld_q;
    logic [O_W-1:0]         out_q;
    int                     shamt;

    // ratio exponent held inside 1..LG_MAX
    always_comb begin
        if (sel == '0)
            sel_c = S_W'(1);
        else if (int'(sel) > LG_MAX)
            sel_c = S_W'(LG_MAX);
        else
            sel_c = sel;
        cnt_last = CNT_W'((32'd1 << sel_c) - 32'd1);
        shamt    = ORDER * int'(sel_c) + TRIM;
    end

    assign x_ext = {{(A_W-IN_W){in_data[IN_W-1]}}, in_data};

    // integrator chain settles within the sample so block edges stay exact
    always_comb begin
        integ_d[0] = integ_q[0] + x_ext;
        for (int k = 1; k < ORDER; k++)
            integ_d[k] = integ_q[k] + integ_d[k-1];
    end

    always_comb begin
        comb_d[0] = dec_q - comb_z[0];
        for (int k = 1; k < ORDER; k++)
            comb_d[k] = comb_d[k-1] - comb_z[k];
        scaled = comb_d[ORDER-1] >>> shamt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            dec_q     <= '0;
            dec_vld   <= 1'b0;
            out_vld_q <= 1'b0;
            out_q     <= '0;
            for (int k = 0; k < ORDER; k++) begin
                integ_q[k] <= '0;
                comb_z[k]  <= '0;
            end
        end else begin
            dec_vld   <= 1'b0;
            out_vld_q <= 1'b0;
            if (in_vld) begin
                for (int k = 0; k < ORDER; k++)
                    integ_q[k] <= integ_d[k];
                if (cnt_q >= cnt_last) begin
                    cnt_q   <= '0;
                    dec_q   <= integ_d[ORDER-1];
                    dec_vld <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            if (dec_vld) begin
                comb_z[0] <= dec_q;
                for (int k = 1; k < ORDER; k++)
                    comb_z[k] <= comb_d[k-1];
                out_q     <= scaled[O_W-1:0];
                out_vld_q <= 1'b1;
            end
        end
    end

    assign out_vld  = out_vld_q;
    assign out_data = out_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        dec_vld |-> ((&scaled[A_W-1:O_W-1]) || !(|scaled[A_W-1:O_W-1])))
        else $error("scaled word exceeds output width"); // R3

    AST_ACC_HEADROOM: assert property (@(posedge clk) disable iff (rst)
        dec_vld |-> (comb_d[ORDER-1][A_W-1] == comb_d[ORDER-1][A_W-2]))
        else $error("comb result lost headroom"); // R3

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_vld_q |=> !out_vld_q)
        else $error("output valid longer than one cycle"); // R7

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= cnt_last)
        else $error("block counter past ratio"); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_vld_q && out_q == '0))
        else $error("reset left output state"); // R10

endmodule

// File: rtl/dmix_phase_det.sv
module dmix_phase_det
    import dmix_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ref_valid,
    input  logic signed [SAMP_W-1:0] ref_sample,
    input  logic [PHASE_W-1:0]       tune_word,
    input  logic [SEL_W-1:0]         dec_sel,
    output logic                     err_valid,
    output logic [OUT_W-1:0]         err_word
);

    mix_pair_t pair;
    mix_prod_t prod;

    dmix_nco u_nco (
        .clk    (clk),
        .rst    (rst),
        .in_vld (ref_valid),
        .in_smp (ref_sample),
        .step   (tune_word),
        .pair_o (pair)
    );

    dmix_mixer u_mixer (
        .clk    (clk),
        .rst    (rst),
        .pair_i (pair),
        .prod_o (prod)
    );

    dmix_cic #(
        .ORDER  (CIC_ORDER),
        .IN_W   (PROD_W),
        .LG_MAX (LOG2_RMAX),
        .A_W    (ACC_W),
        .O_W    (OUT_W),
        .S_W    (SEL_W)
    ) u_cic (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (prod.vld),
        .in_data  (prod.prod),
        .sel      (dec_sel),
        .out_vld  (err_valid),
        .out_data (err_word)
    );

endmodule

// File: tb/dmix_phase_det_bench.sv
module dmix_phase_det_bench;

    localparam real PI2 = 6.283185307179586;

    typedef struct packed {
        logic [31:0]        step;
        logic [2:0]         lg;
        logic [2:0]         kind;   // 0 sin, 1 cos, 2 const, 3 lfsr, 4 alternating
        logic signed [15:0] amp;
        logic [7:0]         nblk;
        logic               gaps;
        logic [1:0]         lock;   // 1 expect large positive, 2 expect near zero
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{32'h1000_0000, 3'd4, 3'd0, 16'sd30000,  8'd8,  1'b0, 2'd1},
        '{32'h1000_0000, 3'd4, 3'd1, 16'sd30000,  8'd8,  1'b1, 2'd2},
        '{32'h1076_3F5E, 3'd3, 3'd3, 16'sd0,      8'd10, 1'b1, 2'd0},
        '{32'hF000_0000, 3'd2, 3'd0, 16'sd20000,  8'd12, 1'b0, 2'd0},
        '{32'h1234_5678, 3'd6, 3'd2, -16'sd32768, 8'd3,  1'b0, 2'd0},
        '{32'h4000_0000, 3'd1, 3'd4, 16'sd32767,  8'd20, 1'b0, 2'd0},
        '{32'h1000_0000, 3'd0, 3'd3, 16'sd0,      8'd16, 1'b1, 2'd0},
        '{32'h1000_0000, 3'd7, 3'd0, 16'sd25000,  8'd2,  1'b0, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        ref_valid;
    logic [15:0] ref_sample;
    logic [31:0] tune_word;
    logic [2:0]  dec_sel;
    logic        err_valid;
    logic [23:0] err_word;

    always #2 clk = ~clk;

    dmix_phase_det u_dmix_phase_det (
        .clk        (clk),
        .rst        (rst),
        .ref_valid  (ref_valid),
        .ref_sample (ref_sample),
        .tune_word  (tune_word),
        .dec_sel    (dec_sel),
        .err_valid  (err_valid),
        .err_word   (err_word)
    );

    int     checks = 0;
    int     fails  = 0;
    longint rxq[$];
    longint expq[$];
    int     smp [1024];
    longint xs  [1024];
    longint m1  [1024];
    longint m2  [1024];
    longint m3  [1024];

    always @(negedge clk)
        if (!rst && err_valid) rxq.push_back(longint'($signed(err_word)));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int round_r(input real v);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    // R4: local sine from the full 10-bit index
    function automatic int local_sine(input logic [9:0] idx);
        real a;
        a = PI2 * (real'(idx) + 0.5) / 1024.0;
        return round_r(32767.0 * $sin(a));
    endfunction

    // R6: selector clamp
    function automatic int clamp_sel(input int l);
        if (l == 0) return 1;
        if (l > 6) return 6;
        return l;
    endfunction

    task automatic gen_samples(input vec_t v, input int n, input logic [15:0] seed);
        logic [31:0] p;
        logic [15:0] lf;
        real         ang;
        p  = '0;
        lf = seed;
        for (int i = 0; i < n; i++) begin
            ang = PI2 * (real'(p[31:22]) + 0.5) / 1024.0;
            case (v.kind)
                3'd0: smp[i] = round_r(real'($signed(v.amp)) * $sin(ang));
                3'd1: smp[i] = round_r(real'($signed(v.amp)) * $cos(ang));
                3'd2: smp[i] = int'($signed(v.amp));
                3'd3: begin
                    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                    smp[i] = int'($signed(lf));
                end
                default: smp[i] = (i % 2 == 0) ? int'($signed(v.amp)) : -int'($signed(v.amp));
            endcase
            p = p + v.step;
        end
    endtask

    // R2, R5, R6: expected words from the stated arithmetic
    task automatic build_expected(input logic [31:0] step, input int lgc, input int n);
        logic [31:0] p;
        int          r;
        longint      s;
        p = '0;
        r = 1 << lgc;
        for (int i = 0; i < n; i++) begin
            xs[i] = longint'(smp[i]) * longint'(local_sine(p[31:22]));
            p = p + step;
        end
        for (int i = 0; i < n; i++) begin
            s = 0;
            for (int k = 0; k < r; k++) if (i - k >= 0) s += xs[i-k];
            m1[i] = s;
        end
        for (int i = 0; i < n; i++) begin
            s = 0;
            for (int k = 0; k < r; k++) if (i - k >= 0) s += m1[i-k];
            m2[i] = s;
        end
        for (int i = 0; i < n; i++) begin
            s = 0;
            for (int k = 0; k < r; k++) if (i - k >= 0) s += m2[i-k];
            m3[i] = s;
        end
        expq.delete();
        for (int j = 0; j * r + r - 1 < n; j++)
            expq.push_back(m3[j*r+r-1] >>> (3 * lgc + 8));
    endtask

    // R8: idle cycles carry a junk sample that must be ignored
    task automatic drive_stream(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_valid  = 1'b1;
            ref_sample = smp[i][15:0];
            if (gaps && (i % 3 == 2)) begin
                @(negedge clk);
                ref_valid  = 1'b0;
                ref_sample = 16'h7FFF;
            end
        end
        @(negedge clk);
        ref_valid = 1'b0;
    endtask

    task automatic run_vector(input vec_t v, input string tag);
        int lgc;
        int n;
        int m;
        lgc = clamp_sel(int'(v.lg));
        n   = int'(v.nblk) << lgc;
        @(negedge clk);
        rst       = 1'b1;
        ref_valid = 1'b0;
        tune_word = v.step;
        dec_sel   = v.lg;
        @(negedge clk);
        rst = 1'b0;
        gen_samples(v, n, 16'hACE1);
        build_expected(v.step, lgc, n);
        rxq.delete();
        drive_stream(n, v.gaps);
        repeat (12) @(negedge clk);
        check(rxq.size() == expq.size(), {"R7 word count ", tag}, rxq.size(), expq.size());
        m = (rxq.size() < expq.size()) ? rxq.size() : expq.size();
        for (int j = 0; j < m; j++)
            check(rxq[j] == expq[j], {"R6 ", tag}, rxq[j], expq[j]);
        if (v.lock == 2'd1 && m > 0)
            check(rxq[m-1] > 64'sd1000000, "R9 in-phase level", rxq[m-1], 1000000);
        if (v.lock == 2'd2 && m > 0)
            check(rxq[m-1] < 64'sd500 && rxq[m-1] > -64'sd500, "R9 quadrature level", rxq[m-1], 0);
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0: return "R4 in-phase";
            1: return "R8 quadrature with gaps";
            2: return "R5 random with gaps";
            3: return "R2 wrapping step";
            4: return "R3 full-scale negative";
            5: return "R4 alternating";
            6: return "R6 selector 0 clamp";
            default: return "R6 selector 7 clamp";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R7 actual=%0d expected=%0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int cyc;
        rst        = 1'b1;
        ref_valid  = 1'b0;
        ref_sample = '0;
        tune_word  = '0;
        dec_sel    = 3'd1;
        repeat (3) @(negedge clk);
        check(err_valid == 1'b0, "R1 reset valid", err_valid, 0);
        check(err_word == '0, "R1 reset word", err_word, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(err_valid == 1'b0, "R1 idle valid", err_valid, 0);

        // vector table
        for (int i = 0; i < NVEC; i++)
            run_vector(VECS[i], tag_of(i));

        // R11 latency, R7 pulse width
        @(negedge clk);
        rst       = 1'b1;
        dec_sel   = 3'd1;
        tune_word = 32'h1000_0000;
        @(negedge clk);
        rst = 1'b0;
        ref_valid  = 1'b1;
        ref_sample = 16'sd1000;
        @(negedge clk);
        ref_sample = 16'sd1000;
        @(posedge clk);
        @(negedge clk);
        ref_valid = 1'b0;
        cyc = 1;
        while (!err_valid && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == 5, "R11 latency edges", cyc, 5);
        @(negedge clk);
        check(err_valid == 1'b0, "R7 single-cycle pulse", err_valid, 0);

        // R10 reset in the middle of a block
        dec_sel   = 3'd2;
        gen_samples(VECS[2], 7, 16'h1D2C);
        drive_stream(7, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(err_valid == 1'b0 && err_word == '0, "R10 cleared outputs", err_word, 0);
        run_vector(VECS[2], "R10 stream after mid-block reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule